// File: doc/BRIEF.md
# Look-Up-Table Logic Cell with Multi-Mode Register

The cell is one fine-grained unit of a programmable fabric. A 16-entry configuration word acts as a truth table over four data inputs, so any Boolean function of those four inputs can be computed. The cell has a second, arithmetic setting. In that setting the table is split into two eight-entry halves. One half forms a sum bit from two data inputs and the incoming carry. The other half forms the outgoing carry. Neighbouring cells chain their carry and cascade signals to each other directly, which gives ripple adders and wide AND-combined functions without going through general routing.

The result of the table, gated by the cascade input, feeds a single storage bit. That bit can be configured as a D, T, JK or SR flip-flop. Its clock comes from a dedicated clock or a global clock. Clear and preset are asynchronous. Each of them is taken from one of three sources: global, pad-side or locally generated. Two output ports, one toward nearby cells and one toward long row/column wires, each choose on their own between the combinational result and the stored bit.

Top module: `lut_cell`

## Requirements
- R1: With `cfg_arith`=0, the combinational result equals `cfg_lut[d_in]`, where bit index `d_in` reads `d_in[3]` as the most significant bit, provided `cascade_in`=1.
- R2: With `cfg_arith`=1, let idx = {`carry_in`,`d_in[1]`,`d_in[0]`}. The combinational result is `cfg_lut[idx]` and `carry_out` is `cfg_lut[8+idx]`. `d_in[3:2]` are ignored. With `cfg_arith`=0, `carry_out` is 0.
- R3: `cascade_out` equals `cascade_in` AND the table result. This same AND is the combinational result that feeds the register and the output selectors.
- R4: `cfg_ff_mode`=0 (D): at each active clock edge the register takes the combinational result.
- R5: `cfg_ff_mode`=1 (T): at each active edge the register inverts when the combinational result is 1 and holds when it is 0.
- R6: `cfg_ff_mode`=2 (JK, J=`aux_a`, K=`aux_b`): 00 holds, 10 sets, 01 clears, 11 toggles.
- R7: `cfg_ff_mode`=3 (SR, S=`aux_a`, R=`aux_b`): 10 sets, 01 clears, and both 00 and 11 hold.
- R8: An active clear source forces the register to 0 at once, without a clock edge. This holds even while a preset is active.
- R9: An active preset source, with no clear active, forces the register to 1 at once.
- R10: `clr_src`/`pre_src` pick the source: 0 = global, 1 = pad-side, 2 = local, 3 = none. Sources that are not picked have no effect.
- R11: `clk_sel`=0 clocks the register from `clk_ded` and `clk_sel`=1 clocks it from `clk_glob`. Edges on the clock that is not selected do not change the register.
- R12: `q_local` and `q_row` each present the register when their select bit (`cfg_sel_local`, `cfg_sel_row`) is 1, and the combinational result when it is 0. The two selects are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ded | input | 1 | Dedicated clock |
| clk_glob | input | 1 | Global clock |
| clk_sel | input | 1 | Register clock choice |
| cfg_lut | input | 16 | Truth table contents |
| cfg_arith | input | 1 | Arithmetic split-table setting |
| cfg_ff_mode | input | 2 | Register type: 0 D, 1 T, 2 JK, 3 SR |
| cfg_sel_local | input | 1 | q_local source: 1 register, 0 combinational |
| cfg_sel_row | input | 1 | q_row source: 1 register, 0 combinational |
| clr_src | input | 2 | Clear source select |
| pre_src | input | 2 | Preset source select |
| d_in | input | 4 | Table address inputs |
| aux_a | input | 1 | J or S input |
| aux_b | input | 1 | K or R input |
| carry_in | input | 1 | Carry from previous cell |
| cascade_in | input | 1 | Cascade from previous cell |
| clr_glob | input | 1 | Global clear, active high |
| clr_io | input | 1 | Pad-side clear, active high |
| clr_loc | input | 1 | Local clear, active high |
| pre_glob | input | 1 | Global preset, active high |
| pre_io | input | 1 | Pad-side preset, active high |
| pre_loc | input | 1 | Local preset, active high |
| carry_out | output | 1 | Carry to next cell |
| cascade_out | output | 1 | Cascade to next cell |
| q_local | output | 1 | Output to nearby cells |
| q_row | output | 1 | Output to row/column wires |

## Verification
The bench first drives the table randomly in both settings against a truth-table model. A cell that indexed the arithmetic half with the wrong bits, or let `d_in[3:2]` leak in, would give a wrong sum or carry. It then steps every JK and SR input pair, including J=K=1 and S=R=1. A design that treated S=R=1 as a set or a reset, or that failed to toggle on J=K=1, would show a wrong stored bit. Clear and preset are applied together, and a cell that let preset win would read 1. Asserting only sources that are not selected exposes a broken source mux. Stopping the selected clock while the other one runs catches a swapped clock choice.

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int N_IN = 4,
  localparam int DEPTH = 1 << N_IN
) (
  input  logic             clk_ded,
  input  logic             clk_glob,
  input  logic             clk_sel,
  input  logic [DEPTH-1:0] cfg_lut,
  input  logic             cfg_arith,
  input  logic [1:0]       cfg_ff_mode,
  input  logic             cfg_sel_local,
  input  logic             cfg_sel_row,
  input  logic [1:0]       clr_src,
  input  logic [1:0]       pre_src,
  input  logic [N_IN-1:0]  d_in,
  input  logic             aux_a,
  input  logic             aux_b,
  input  logic             carry_in,
  input  logic             cascade_in,
  input  logic             clr_glob,
  input  logic             clr_io,
  input  logic             clr_loc,
  input  logic             pre_glob,
  input  logic             pre_io,
  input  logic             pre_loc,
  output logic             carry_out,
  output logic             cascade_out,
  output logic             q_local,
  output logic             q_row
);
  localparam logic [1:0] M_D = 2'd0, M_T = 2'd1, M_JK = 2'd2, M_SR = 2'd3;

  logic [N_IN-2:0] idx_a;
  logic lut_out, comb, ff_clk, clr_act, pre_act, q, q_nxt;

  assign idx_a       = {carry_in, d_in[N_IN-3:0]};
  assign lut_out     = cfg_arith ? cfg_lut[{1'b0, idx_a}] : cfg_lut[d_in];
  assign carry_out   = cfg_arith & cfg_lut[{1'b1, idx_a}];
  assign cascade_out = cascade_in & lut_out;
  assign comb        = cascade_out;
  assign ff_clk      = clk_sel ? clk_glob : clk_ded;

  always_comb begin
    case (clr_src)
      2'd0:    clr_act = clr_glob;
      2'd1:    clr_act = clr_io;
      2'd2:    clr_act = clr_loc;
      default: clr_act = 1'b0;
    endcase
    case (pre_src)
      2'd0:    pre_act = pre_glob;
      2'd1:    pre_act = pre_io;
      2'd2:    pre_act = pre_loc;
      default: pre_act = 1'b0;
    endcase
  end

  always_comb begin
    case (cfg_ff_mode)
      M_D:  q_nxt = comb;
      M_T:  q_nxt = q ^ comb;
      M_JK: q_nxt = (aux_a & ~q) | (~aux_b & q);
      M_SR: q_nxt = (aux_a & ~aux_b) ? 1'b1 : (~aux_a & aux_b) ? 1'b0 : q;
      default: q_nxt = q;
    endcase
  end

  always_ff @(posedge ff_clk or posedge clr_act or posedge pre_act) begin
    if (clr_act)      q <= 1'b0;
    else if (pre_act) q <= 1'b1;
    else              q <= q_nxt;
  end

  assign q_local = cfg_sel_local ? q : comb;
  assign q_row   = cfg_sel_row   ? q : comb;
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk (
  input logic       ff_clk,
  input logic       clr_act,
  input logic       pre_act,
  input logic [1:0] cfg_ff_mode,
  input logic       aux_a,
  input logic       aux_b,
  input logic       comb,
  input logic       q,
  input logic       cascade_in,
  input logic       cascade_out,
  input logic       cfg_arith,
  input logic       carry_out
);
  a_r4_d_follows: assert property (@(posedge ff_clk) disable iff (clr_act || pre_act)
    cfg_ff_mode == 2'd0 |=> q == $past(comb));
  a_r6_jk_toggle: assert property (@(posedge ff_clk) disable iff (clr_act || pre_act)
    (cfg_ff_mode == 2'd2 && aux_a && aux_b) |=> q != $past(q));
  a_r7_sr_both_hold: assert property (@(posedge ff_clk) disable iff (clr_act || pre_act)
    (cfg_ff_mode == 2'd3 && aux_a && aux_b) |=> q == $past(q));

  always @(negedge ff_clk) begin
    if (clr_act) a_r8_clear_wins: assert (q == 1'b0);
    if (pre_act && !clr_act) a_r9_preset: assert (q == 1'b1);
    if (!cascade_in) a_r3_cascade_block: assert (!cascade_out);
    if (!cfg_arith) a_r2_no_carry: assert (!carry_out);
  end
endmodule

bind lut_cell lut_cell_chk chk (.*);

// File: tb/lut_cell_test.sv
module lut_cell_test;
  localparam int CLK_P = 10;

  logic clk = 0, gclk = 0, clk_sel = 0;
  logic [15:0] cfg = 16'h0;
  logic arith = 0, sel_l = 0, sel_r = 1, aux_a = 0, aux_b = 0, ci = 0, casc = 1;
  logic [1:0] mode = 2'd0, clr_src = 2'd0, pre_src = 2'd3;
  logic [3:0] d = 4'h0;
  logic clr_g = 0, clr_i = 0, clr_l = 0, pre_g = 0, pre_i = 0, pre_l = 0;
  logic carry_out, cascade_out, q_local, q_row;
  logic q_exp = 0, done = 0;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  lut_cell uut (
    .clk_ded(clk), .clk_glob(gclk), .clk_sel(clk_sel), .cfg_lut(cfg),
    .cfg_arith(arith), .cfg_ff_mode(mode), .cfg_sel_local(sel_l), .cfg_sel_row(sel_r),
    .clr_src(clr_src), .pre_src(pre_src), .d_in(d), .aux_a(aux_a), .aux_b(aux_b),
    .carry_in(ci), .cascade_in(casc), .clr_glob(clr_g), .clr_io(clr_i), .clr_loc(clr_l),
    .pre_glob(pre_g), .pre_io(pre_i), .pre_loc(pre_l), .carry_out(carry_out),
    .cascade_out(cascade_out), .q_local(q_local), .q_row(q_row));

  function automatic logic f_lut(logic [15:0] t, logic ar, logic [3:0] a, logic c);
    return ar ? t[{1'b0, c, a[1:0]}] : t[a];
  endfunction
  function automatic logic f_cy(logic [15:0] t, logic ar, logic [3:0] a, logic c);
    return ar ? t[{1'b1, c, a[1:0]}] : 1'b0;
  endfunction
  function automatic logic f_next(logic [1:0] m, logic cur, logic c, logic a, logic b);
    case (m)
      2'd0: return c;
      2'd1: return c ? ~cur : cur;
      2'd2: return (a && b) ? ~cur : a ? 1'b1 : b ? 1'b0 : cur;
      default: return (a && !b) ? 1'b1 : (!a && b) ? 1'b0 : cur;
    endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag);
    logic e;
    @(negedge clk);
    e = f_lut(cfg, arith, d, ci) & casc;
    chk(arith ? "R2 sum" : "R1 lut", q_local, e);
    chk("R3 cascade", cascade_out, e);
    chk("R2 carry", carry_out, f_cy(cfg, arith, d, ci));
    chk(tag, q_row, q_exp);
    @(posedge clk);
    q_exp = f_next(mode, q_exp, e, aux_a, aux_b);
    #1;
  endtask

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    #2 clr_g = 1;
    @(negedge clk); chk("R8 reset", q_row, 1'b0);
    @(posedge clk); #1 clr_g = 0; q_exp = 0;

    for (int i = 0; i < 300; i++) begin
      cfg = 16'($urandom); d = 4'($urandom); ci = 1'($urandom);
      arith = 1'($urandom); casc = ($urandom % 4) != 0;
      cyc("R4 d-mode");
    end
    arith = 0; casc = 1;

    mode = 2'd1; cfg = 16'hFFFF;
    repeat (3) cyc("R5 toggle");
    cfg = 16'h0000;
    repeat (2) cyc("R5 hold");

    mode = 2'd2;
    aux_a = 1; aux_b = 0; cyc("R6 set");
    aux_a = 0; aux_b = 0; cyc("R6 hold");
    aux_a = 0; aux_b = 1; cyc("R6 reset");
    aux_a = 1; aux_b = 1; cyc("R6 toggle");
    cyc("R6 toggle2");

    mode = 2'd3;
    aux_a = 1; aux_b = 0; cyc("R7 set");
    aux_a = 1; aux_b = 1; cyc("R7 both-hold");
    aux_a = 0; aux_b = 1; cyc("R7 reset");
    aux_a = 1; aux_b = 1; cyc("R7 both-hold0");
    aux_a = 0; aux_b = 0; cyc("R7 idle");

    pre_src = 2'd2; pre_l = 1;
    @(negedge clk); chk("R9 preset", q_row, 1'b1);
    @(posedge clk); #1 clr_src = 2'd1; clr_i = 1;
    @(negedge clk); chk("R8 clear over preset", q_row, 1'b0);
    @(posedge clk); #1 clr_i = 0; pre_l = 0; q_exp = 0;

    aux_a = 1; cyc("R7 set"); aux_a = 0;
    clr_src = 2'd3; clr_g = 1; clr_i = 1; clr_l = 1;
    repeat (2) cyc("R10 clear none");
    clr_src = 2'd0; clr_g = 0;
    cyc("R10 clear unselected");
    clr_i = 0; clr_l = 0;
    aux_b = 1; cyc("R7 reset"); aux_b = 0;
    pre_src = 2'd1; pre_g = 1; pre_l = 1;
    repeat (2) cyc("R10 preset unselected");
    pre_g = 0; pre_l = 0; pre_src = 2'd3;

    mode = 2'd0; cfg = 16'hFFFF; casc = 1; clk_sel = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk("R11 dedicated ignored", q_row, 1'b0);
    gclk = 1; #1 gclk = 0; #1;
    chk("R11 global clocks", q_row, 1'b1);
    clk_sel = 0; q_exp = 1;
    @(posedge clk); #1;

    mode = 2'd3; cfg = 16'h0000; sel_l = 1; sel_r = 0;
    @(negedge clk);
    chk("R12 local reg", q_local, 1'b1);
    chk("R12 row comb", q_row, 1'b0);
    @(posedge clk); #1 sel_l = 0; sel_r = 1;

    cfg = 16'hFFFF; casc = 0; cyc("R3 blocked");
    casc = 1; cyc("R3 pass");

    arith = 1; cfg = 16'hE896;
    d = 4'b1111; ci = 1;
    @(negedge clk); chk("R2 sum 1+1+1", q_local, 1'b1); chk("R2 cy 1+1+1", carry_out, 1'b1);
    @(posedge clk); #1 d = 4'b1101;
    @(negedge clk); chk("R2 sum 1+0+1", q_local, 1'b0); chk("R2 cy 1+0+1", carry_out, 1'b1);
    @(posedge clk); #1 d = 4'b1100; ci = 0;
    @(negedge clk); chk("R2 sum 0+0+0", q_local, 1'b0); chk("R2 cy 0+0+0", carry_out, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule